// File: doc/BRIEF.md
# Interrupt Source Front End

This block is the register side of a 32-source interrupt controller. Hardware request lines are level sensitive. Each line passes through a two-stage synchronizer and is then held in a level register. Software can raise requests of its own through a separate soft-request register. The pending vector is the OR of the hardware level and the soft level. From it the block forms two results:

- a masked IRQ request vector, which feeds a priority unit outside this block;
- a single fast-interrupt (FIQ) line.

Each source has an enable bit and a steering bit. A source whose steering bit is set goes to the FIQ line, and the enable mask does not gate that path. A source whose steering bit is clear goes to the IRQ vector only when its enable bit is set.

A word-addressed register bus gives software access to the block. It has separate read and write strobes. Each register is set to its new value at the clock edge where the write strobe is sampled. The IRQ vector and the FIQ line follow from the register outputs, so they show a write in the cycle after it. Read data is registered.

Top module: `irq_src_front`

## Requirements
- R1: After reset the enable, steering, soft-request, level and protection registers are zero. The IRQ vector, the FIQ line and the read data are also zero.
- R2: A change on a hardware request line reaches the pending vector on the third rising clock edge after the change: two synchronizer edges, then the level register. The IRQ vector and the FIQ line change together with it.
- R3: The IRQ vector equals pending AND enable AND NOT steering, where pending is hardware level OR soft level.
- R4: The FIQ line is high exactly when pending AND steering is nonzero. The enable mask has no effect on it.
- R5: A write to word 4 (byte 0x10) ORs the data into the enable mask. A write to word 5 (byte 0x14) clears the enable bits set in the data. A read of word 4 returns the mask.
- R6: A write to word 6 (byte 0x18) ORs the data into the soft-request register. A write to word 7 (byte 0x1C) clears the soft-request bits set in the data. A read of word 6 returns the soft-request register.
- R7: Word 3 (byte 0x0C) is the steering mask. A write replaces it and a read returns it.
- R8: A write to word 8 (byte 0x20) stores only data bit 0 as the protection flag. A read of word 8 returns that flag in bit 0, with all other bits zero.
- R9: Status reads:
  - word 0 (byte 0x00) returns the IRQ vector;
  - word 1 (byte 0x04) returns pending AND steering;
  - word 2 (byte 0x08) returns the raw pending vector.
- R10: Words 0x3F8 to 0x3FF (bytes 0xFE0 to 0xFFC) return one identification byte each, zero-extended, in word order: 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Writes to the following words change no state: word 0, the identification words, and any unmapped word. A read of an unmapped word returns zero. The write-only words 5 and 7 count as unmapped for reads.
- R12: Read data appears on `bus_rdata` after the rising edge that samples `bus_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_req | input | 32 | Asynchronous level-sensitive request lines |
| bus_addr | input | 10 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_vec | output | 32 | Masked IRQ request vector to the priority unit |
| fiq_out | output | 1 | Fast-interrupt request |

## Verification
A register write is due on `irq_vec` and `fiq_out` one edge after the write strobe is sampled. The bench therefore compares these outputs at the falling edge that follows the write. A hardware line change is due three edges after it is driven. The bench checks at the second falling edge that the old value still holds, then checks at the third that the new value has arrived. Read data is due one edge after `bus_rd`. The driver queues the expected word when it raises the strobe, and the monitor pops and compares it at the next falling edge.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  // Word indices of the register map
  localparam int W_IRQ_STAT = 0;
  localparam int W_FIQ_STAT = 1;
  localparam int W_RAW      = 2;
  localparam int W_STEER    = 3;
  localparam int W_EN_SET   = 4;
  localparam int W_EN_CLR   = 5;
  localparam int W_SOFT_SET = 6;
  localparam int W_SOFT_CLR = 7;
  localparam int W_PROT     = 8;
  localparam int W_ID_BASE  = 'h3F8;
  localparam int W_ID_LAST  = 'h3FF;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_IRQ, SEL_FIQ, SEL_RAW, SEL_STEER,
    SEL_EN, SEL_SOFT, SEL_PROT, SEL_ID
  } rd_sel_e;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h90;
      3'd1: id_byte = 8'h11;
      3'd2: id_byte = 8'h04;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic logic [31:0] route_irq(input logic [31:0] pend,
                                            input logic [31:0] en,
                                            input logic [31:0] steer);
    route_irq = pend & en & ~steer;
  endfunction

  function automatic logic route_fiq(input logic [31:0] pend,
                                     input logic [31:0] steer);
    route_fiq = |(pend & steer);
  endfunction
endpackage

// File: rtl/req_sync.sv
module req_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mask_regs.sv
module mask_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         wr_en_set,
  input  logic         wr_en_clr,
  input  logic         wr_soft_set,
  input  logic         wr_soft_clr,
  input  logic         wr_steer,
  input  logic         wr_prot,
  output logic [W-1:0] en_q,
  output logic [W-1:0] soft_q,
  output logic [W-1:0] steer_q,
  output logic         prot_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      soft_q  <= '0;
      steer_q <= '0;
      prot_q  <= 1'b0;
    end else begin
      if (wr_en_set)   en_q    <= en_q | wdata;
      if (wr_en_clr)   en_q    <= en_q & ~wdata;
      if (wr_soft_set) soft_q  <= soft_q | wdata;
      if (wr_soft_clr) soft_q  <= soft_q & ~wdata;
      if (wr_steer)    steer_q <= wdata;
      if (wr_prot)     prot_q  <= wdata[0];
    end
  end

  // R5
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_set |=> ((en_q & $past(wdata)) == $past(wdata)));
  // R5
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_clr |=> ((en_q & $past(wdata)) == '0));
  // R6
  soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_soft_set |=> ((soft_q & $past(wdata)) == $past(wdata)));
  // R6
  soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_soft_clr |=> ((soft_q & $past(wdata)) == '0));
  // R8
  prot_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prot |=> (prot_q == $past(wdata[0])));
endmodule

// File: rtl/regs_rdmux.sv
module regs_rdmux
  import irq_src_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  rd_sel_e      sel,
  input  logic [2:0]   id_idx,
  input  logic [W-1:0] irq_v,
  input  logic [W-1:0] fiq_v,
  input  logic [W-1:0] raw_v,
  input  logic [W-1:0] steer_v,
  input  logic [W-1:0] en_v,
  input  logic [W-1:0] soft_v,
  input  logic         prot_v,
  output logic [W-1:0] rdata
);
  logic [W-1:0] mux_d;

  always_comb begin
    unique case (sel)
      SEL_IRQ:   mux_d = irq_v;
      SEL_FIQ:   mux_d = fiq_v;
      SEL_RAW:   mux_d = raw_v;
      SEL_STEER: mux_d = steer_v;
      SEL_EN:    mux_d = en_v;
      SEL_SOFT:  mux_d = soft_v;
      SEL_PROT:  mux_d = {{(W-1){1'b0}}, prot_v};
      SEL_ID:    mux_d = {{(W-8){1'b0}}, id_byte(id_idx)};
      default:   mux_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= mux_d;

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));
  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/irq_src_front.sv
module irq_src_front
  import irq_src_pkg::*;
#(
  parameter int NSRC        = 32,
  parameter int ADDR_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   hw_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic [NSRC-1:0]   irq_vec,
  output logic              fiq_out
);
  localparam int AIDX = int'(1) << ADDR_W;

  logic [NSRC-1:0] hw_sync, level_q;
  logic [NSRC-1:0] en_q, soft_q, steer_q;
  logic            prot_q;
  logic [NSRC-1:0] pending, fiq_stat;
  int              widx;
  logic            is_id;
  logic wr_en_set, wr_en_clr, wr_soft_set, wr_soft_clr, wr_steer, wr_prot;
  logic wr_hit;
  rd_sel_e rsel;

  req_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(hw_req), .sync_out(hw_sync));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) level_q <= '0;
    else        level_q <= hw_sync;

  assign widx  = int'(bus_addr);
  assign is_id = (widx >= W_ID_BASE) && (widx <= W_ID_LAST) && (W_ID_LAST < AIDX);

  assign wr_en_set   = bus_wr && widx == W_EN_SET;
  assign wr_en_clr   = bus_wr && widx == W_EN_CLR;
  assign wr_soft_set = bus_wr && widx == W_SOFT_SET;
  assign wr_soft_clr = bus_wr && widx == W_SOFT_CLR;
  assign wr_steer    = bus_wr && widx == W_STEER;
  assign wr_prot     = bus_wr && widx == W_PROT;
  assign wr_hit = wr_en_set | wr_en_clr | wr_soft_set | wr_soft_clr | wr_steer | wr_prot;

  mask_regs #(.W(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata),
    .wr_en_set(wr_en_set), .wr_en_clr(wr_en_clr),
    .wr_soft_set(wr_soft_set), .wr_soft_clr(wr_soft_clr),
    .wr_steer(wr_steer), .wr_prot(wr_prot),
    .en_q(en_q), .soft_q(soft_q), .steer_q(steer_q), .prot_q(prot_q));

  assign pending  = level_q | soft_q;
  assign fiq_stat = pending & steer_q;
  assign irq_vec  = route_irq(pending, en_q, steer_q);
  assign fiq_out  = route_fiq(pending, steer_q);

  always_comb begin
    rsel = SEL_NONE;
    if (is_id) rsel = SEL_ID;
    else begin
      case (widx)
        W_IRQ_STAT: rsel = SEL_IRQ;
        W_FIQ_STAT: rsel = SEL_FIQ;
        W_RAW:      rsel = SEL_RAW;
        W_STEER:    rsel = SEL_STEER;
        W_EN_SET:   rsel = SEL_EN;
        W_SOFT_SET: rsel = SEL_SOFT;
        W_PROT:     rsel = SEL_PROT;
        default:    rsel = SEL_NONE;
      endcase
    end
  end

  regs_rdmux #(.W(NSRC)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .sel(rsel),
    .id_idx(bus_addr[2:0]), .irq_v(irq_vec), .fiq_v(fiq_stat),
    .raw_v(pending), .steer_v(steer_q), .en_v(en_q), .soft_v(soft_q),
    .prot_v(prot_q), .rdata(bus_rdata));

  // R3
  irq_not_steered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec & steer_q) == '0);
  // R4
  fiq_needs_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_q == '0) |-> !fiq_out);
  // R11
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !wr_hit) |=> ($stable(en_q) && $stable(soft_q) && $stable(steer_q) && $stable(prot_q)));
  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (level_q == $past(hw_sync)));
endmodule

// File: tb/irq_src_front_tb.sv
module irq_src_front_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] hw_req = '0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, irq_vec;
  logic        fiq_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_src_front dut_i (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_vec(irq_vec), .fiq_out(fiq_out));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: R12 read data due one edge after the strobe
  always @(posedge clk) rd_seen <= bus_rd && rst_n;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  task automatic rd(input int waddr, input logic [31:0] exp, input string tag);
    bus_addr = 10'(waddr);
    bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr(input int waddr, input logic [31:0] data);
    bus_addr = 10'(waddr);
    bus_wdata = data;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] ids [8];
    ids = '{8'h90, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 irq_vec", irq_vec, '0);
    check("R1 fiq_out", 32'(fiq_out), '0);
    check("R1 rdata", bus_rdata, '0);
    rd(2, '0, "R1 raw");
    rd(4, '0, "R1 enable");

    wr(3, 32'h1);
    rd(3, 32'h1, "R7 steer");
    hw_req = 32'h1;
    idle(2);
    check("R2 two edges old", 32'(fiq_out), 0);
    idle(1);
    check("R2 third edge new", 32'(fiq_out), 1);
    check("R4 fiq without enable", 32'(fiq_out), 1);
    rd(1, 32'h1, "R9 fiq status");
    rd(0, '0, "R9 irq status");

    wr(4, 32'h0000_00FF);
    wr(4, 32'h0000_FF00);
    rd(4, 32'h0000_FFFF, "R5 enable set");
    wr(5, 32'h0000_0F0F);
    rd(4, 32'h0000_F0F0, "R5 enable clear");

    hw_req = 32'h0000_00F1;
    idle(3);
    check("R3 irq_vec", irq_vec, 32'h0000_00F0);
    rd(2, 32'h0000_00F1, "R9 raw");
    rd(0, 32'h0000_00F0, "R9 irq status");

    wr(6, 32'h0000_1100);
    check("R3 irq_vec soft", irq_vec, 32'h0000_10F0);
    rd(6, 32'h0000_1100, "R6 soft set");
    wr(7, 32'h0000_0100);
    rd(6, 32'h0000_1000, "R6 soft clear");
    rd(2, 32'h0000_10F1, "R9 raw soft");

    wr(3, 32'h0000_1000);
    check("R7 irq after steer", irq_vec, 32'h0000_00F0);
    check("R4 fiq steered soft", 32'(fiq_out), 1);
    rd(1, 32'h0000_1000, "R9 fiq status");

    wr(5, 32'hFFFF_FFFF);
    check("R3 irq none enabled", irq_vec, '0);
    check("R4 fiq ignores enable", 32'(fiq_out), 1);
    wr(3, 32'h0000_0002);
    check("R4 fiq no pending steer", 32'(fiq_out), 0);
    wr(3, 32'h0000_1000);

    wr(8, 32'hFFFF_FFFE);
    rd(8, 32'h0, "R8 prot bit0 only");
    wr(8, 32'h0000_0003);
    rd(8, 32'h1, "R8 prot set");

    for (int i = 0; i < 8; i++) rd(32'h3F8 + i, 32'(ids[i]), "R10 id byte");

    wr(0, 32'hFFFF_FFFF);
    wr(32'h0A, 32'hFFFF_FFFF);
    wr(32'h3F9, 32'hFFFF_FFFF);
    check("R11 irq after stray", irq_vec, '0);
    rd(4, '0, "R11 enable kept");
    rd(6, 32'h0000_1000, "R11 soft kept");
    rd(3, 32'h0000_1000, "R11 steer kept");
    rd(8, 32'h1, "R11 prot kept");
    rd(32'h0A, '0, "R11 unmapped read");
    rd(5, '0, "R11 clear word read");
    rd(7, '0, "R11 soft clear word read");
    idle(2);
    check("R12 rdata holds", bus_rdata, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule